// File: doc/BRIEF.md
# Delay-Tap Eye-Centering Calibrator

This block picks the sampling point of a source-synchronous serial receiver. It drives an adjustable delay line that sits on the capture clock path. The data lanes keep fixed delays. A calibration run steps the delay through all 32 positions, from 0 up to 31. At each position the block compares the deserialized words against a known training pattern. With a 200 MHz delay reference, one step is roughly 78 ps, so a whole sweep moves the clock by about 2.4 ns.

A position counts as error-free only when a full run of consecutive words matches the pattern exactly. The first words after each delay change are not compared, so the delay line has time to settle. When the sweep ends, the block loads the midpoint of the lowest and highest error-free positions, rounded down. If no position is error-free, it reports a failure and parks the delay at position 0. Software or a link manager starts a run with a one-cycle request while the block is idle. It then waits for done and reads fail.

Top module: `eye_center_cal`

## Requirements
- R1: After reset, tap_o is 0 and load_o, busy_o, done_o and fail_o are all low.
- R2: A start_i pulse seen while idle raises busy_o on the next cycle. In that same cycle done_o and fail_o are low, tap_o is 0 and load_o is high.
- R3: During a sweep, tap_o takes the values 0, 1, … 31 in that order. Each new value appears with a load_o pulse exactly one cycle long. One run issues exactly 33 load pulses: 32 sweep positions plus the final tap.
- R4: The first SETTLE_CYCLES words after each load pulse are not compared. Mismatches in that window do not affect the verdict.
- R5: A tap passes only if PASS_WORDS consecutive compared words equal pattern_i exactly. One mismatch fails the tap, whether it is the first compared word or the last.
- R6: If any tap passed, the final load sets tap_o to floor((lowest passing tap + highest passing tap) / 2) and fail_o is low. Taps that failed between the lowest and highest passing taps do not change this.
- R7: If no tap passed, fail_o goes high and the final load sets tap_o to 0.
- R8: busy_o stays high from the start cycle through the cycle that shows the final load pulse. On the next cycle busy_o is low and done_o is high. done_o then stays high until the next accepted start.
- R9: A start_i pulse while busy_o is high is ignored. The sweep continues and gives the same load count and the same result.
- R10: tap_o changes only in a cycle where load_o is high. It holds its value after done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Word clock (divided capture clock) |
| rst_i | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Calibration request, one-cycle pulse |
| word_i | input | WORD_W | Deserialized data word, one per cycle |
| pattern_i | input | WORD_W | Expected training word for this cycle |
| tap_o | output | TAP_W | Delay setting sent to the delay line |
| load_o | output | 1 | One-cycle strobe that applies tap_o |
| busy_o | output | 1 | Calibration in progress |
| done_o | output | 1 | Calibration finished, result valid |
| fail_o | output | 1 | No error-free tap was found |

## Verification
The hardest case to reach from the ports is a tap whose outcome depends on one single word. Examples are a mismatch that falls only in the settle window, and must be ignored, or a mismatch only on the first or the last compared word, and must fail the tap. The bench models the delay line. It counts words from each load pulse and gives every tap a class: clean, always wrong, noisy only while settling, wrong only on the first compared word, or wrong only on the last. It mixes these classes at random around directed windows, so the edges of each window are found at exactly those words.

// File: rtl/ecc_pkg.sv
package ecc_pkg;
   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_SETTLE  = 3'd1,
      ST_CHECK   = 3'd2,
      ST_RESOLVE = 3'd3,
      ST_FINISH  = 3'd4
   } cal_state_t;
endpackage

// File: rtl/ecc_word_judge.sv
module ecc_word_judge #(
   parameter int WORD_W     = 8,
   parameter int PASS_WORDS = 64
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              clear_i,
   input  logic              enable_i,
   input  logic [WORD_W-1:0] word_i,
   input  logic [WORD_W-1:0] pattern_i,
   output logic              tap_good_o,
   output logic              tap_bad_o
);
   localparam int CNT_W = $clog2(PASS_WORDS + 1);
   localparam logic [CNT_W-1:0] LAST_RUN = CNT_W'(PASS_WORDS - 1);

   logic [CNT_W-1:0] run_q;
   logic             match;

   assign match      = (word_i == pattern_i);
   assign tap_bad_o  = enable_i && !match;
   assign tap_good_o = enable_i && match && (run_q == LAST_RUN);

   always_ff @(posedge clk_i) begin
      if (rst_i || clear_i) begin
         run_q <= '0;
      end else if (enable_i && match) begin
         run_q <= run_q + 1'b1;
      end
   end
endmodule

// File: rtl/ecc_window_track.sv
module ecc_window_track #(
   parameter int TAP_W = 5
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             clear_i,
   input  logic             record_i,
   input  logic [TAP_W-1:0] tap_i,
   output logic             found_o,
   output logic [TAP_W-1:0] center_o
);
   logic [TAP_W-1:0] lo_q, hi_q;
   logic [TAP_W:0]   span_sum;

   always_ff @(posedge clk_i) begin
      if (rst_i || clear_i) begin
         found_o <= 1'b0;
         lo_q    <= '0;
         hi_q    <= '0;
      end else if (record_i) begin
         found_o <= 1'b1;
         if (!found_o || tap_i < lo_q) lo_q <= tap_i;
         if (!found_o || tap_i > hi_q) hi_q <= tap_i;
      end
   end

   assign span_sum = {1'b0, lo_q} + {1'b0, hi_q};
   assign center_o = span_sum[TAP_W:1];
endmodule

// File: rtl/ecc_sweep_ctrl.sv
module ecc_sweep_ctrl
   import ecc_pkg::*;
#(
   parameter int TAP_W         = 5,
   parameter int SETTLE_CYCLES = 4
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             start_i,
   input  logic             tap_good_i,
   input  logic             tap_bad_i,
   input  logic             found_i,
   input  logic [TAP_W-1:0] center_i,
   output logic             judge_clear_o,
   output logic             judge_en_o,
   output logic             win_clear_o,
   output logic             win_record_o,
   output logic [TAP_W-1:0] tap_o,
   output logic             load_o,
   output logic             busy_o,
   output logic             done_o,
   output logic             fail_o
);
   localparam int SET_W = $clog2(SETTLE_CYCLES + 1);
   localparam logic [SET_W-1:0] SETTLE_LAST = SET_W'(SETTLE_CYCLES - 1);
   localparam logic [TAP_W-1:0] LAST_TAP = '1;

   cal_state_t       state_q;
   logic [SET_W-1:0] settle_q;

   assign judge_en_o    = (state_q == ST_CHECK);
   assign judge_clear_o = (state_q != ST_CHECK);
   assign win_clear_o   = (state_q == ST_IDLE) && start_i;
   assign win_record_o  = (state_q == ST_CHECK) && tap_good_i;
   assign busy_o        = (state_q != ST_IDLE);

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         state_q  <= ST_IDLE;
         settle_q <= '0;
         tap_o    <= '0;
         load_o   <= 1'b0;
         done_o   <= 1'b0;
         fail_o   <= 1'b0;
      end else begin
         load_o <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  tap_o    <= '0;
                  load_o   <= 1'b1;
                  done_o   <= 1'b0;
                  fail_o   <= 1'b0;
                  settle_q <= '0;
                  state_q  <= ST_SETTLE;
               end
            end
            ST_SETTLE: begin
               if (settle_q == SETTLE_LAST) state_q <= ST_CHECK;
               else settle_q <= settle_q + 1'b1;
            end
            ST_CHECK: begin
               if (tap_good_i || tap_bad_i) begin
                  if (tap_o == LAST_TAP) begin
                     state_q <= ST_RESOLVE;
                  end else begin
                     tap_o    <= tap_o + 1'b1;
                     load_o   <= 1'b1;
                     settle_q <= '0;
                     state_q  <= ST_SETTLE;
                  end
               end
            end
            ST_RESOLVE: begin
               tap_o   <= found_i ? center_i : '0;
               fail_o  <= !found_i;
               load_o  <= 1'b1;
               state_q <= ST_FINISH;
            end
            ST_FINISH: begin
               done_o  <= 1'b1;
               state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/eye_center_cal.sv
module eye_center_cal #(
   parameter int TAP_W         = 5,
   parameter int WORD_W        = 8,
   parameter int SETTLE_CYCLES = 4,
   parameter int PASS_WORDS    = 64
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              start_i,
   input  logic [WORD_W-1:0] word_i,
   input  logic [WORD_W-1:0] pattern_i,
   output logic [TAP_W-1:0]  tap_o,
   output logic              load_o,
   output logic              busy_o,
   output logic              done_o,
   output logic              fail_o
);
   generate
      if (TAP_W < 1 || TAP_W > 8) begin : g_bad_tap_w
         $error("eye_center_cal: TAP_W must be 1..8");
      end
      if (WORD_W < 1) begin : g_bad_word_w
         $error("eye_center_cal: WORD_W must be at least 1");
      end
      if (SETTLE_CYCLES < 1) begin : g_bad_settle
         $error("eye_center_cal: SETTLE_CYCLES must be at least 1");
      end
      if (PASS_WORDS < 1) begin : g_bad_pass
         $error("eye_center_cal: PASS_WORDS must be at least 1");
      end
   endgenerate

   logic             tap_good, tap_bad, found;
   logic             judge_clear, judge_en, win_clear, win_record;
   logic [TAP_W-1:0] center;

   ecc_word_judge #(.WORD_W(WORD_W), .PASS_WORDS(PASS_WORDS)) u_judge (
      .clk_i     (clk_i),
      .rst_i     (rst_i),
      .clear_i   (judge_clear),
      .enable_i  (judge_en),
      .word_i    (word_i),
      .pattern_i (pattern_i),
      .tap_good_o(tap_good),
      .tap_bad_o (tap_bad)
   );

   ecc_window_track #(.TAP_W(TAP_W)) u_window (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .clear_i (win_clear),
      .record_i(win_record),
      .tap_i   (tap_o),
      .found_o (found),
      .center_o(center)
   );

   ecc_sweep_ctrl #(.TAP_W(TAP_W), .SETTLE_CYCLES(SETTLE_CYCLES)) u_ctrl (
      .clk_i        (clk_i),
      .rst_i        (rst_i),
      .start_i      (start_i),
      .tap_good_i   (tap_good),
      .tap_bad_i    (tap_bad),
      .found_i      (found),
      .center_i     (center),
      .judge_clear_o(judge_clear),
      .judge_en_o   (judge_en),
      .win_clear_o  (win_clear),
      .win_record_o (win_record),
      .tap_o        (tap_o),
      .load_o       (load_o),
      .busy_o       (busy_o),
      .done_o       (done_o),
      .fail_o       (fail_o)
   );
endmodule

// File: rtl/ecc_checker.sv
module ecc_checker #(
   parameter int TAP_W = 5
) (
   input logic             clk_i,
   input logic             rst_i,
   input logic             start_i,
   input logic [TAP_W-1:0] tap_o,
   input logic             load_o,
   input logic             busy_o,
   input logic             done_o,
   input logic             fail_o
);
   assert_single_pulse_R3: assert property (@(posedge clk_i) disable iff (rst_i)
      load_o |=> !load_o);

   assert_tap_moves_with_load_R10: assert property (@(posedge clk_i) disable iff (rst_i)
      (tap_o != $past(tap_o)) |-> load_o);

   assert_start_loads_zero_R2: assert property (@(posedge clk_i) disable iff (rst_i)
      $rose(busy_o) |-> (load_o && tap_o == '0 && !done_o && !fail_o));

   assert_done_after_busy_R8: assert property (@(posedge clk_i) disable iff (rst_i)
      $fell(busy_o) |-> done_o);

   assert_busy_excludes_done_R8: assert property (@(posedge clk_i) disable iff (rst_i)
      busy_o |-> !done_o);

   assert_done_holds_R8: assert property (@(posedge clk_i) disable iff (rst_i)
      ($past(done_o) && !$past(start_i)) |-> done_o);

   assert_fail_parks_zero_R7: assert property (@(posedge clk_i) disable iff (rst_i)
      fail_o |-> (tap_o == '0));

   assert_start_ignored_busy_R9: assert property (@(posedge clk_i) disable iff (rst_i)
      ($past(busy_o) && $past(start_i) && busy_o) |-> !(load_o && tap_o == '0 && $past(tap_o) != '0));
endmodule

bind eye_center_cal ecc_checker #(.TAP_W(TAP_W)) u_ecc_checker (
   .clk_i  (clk_i),
   .rst_i  (rst_i),
   .start_i(start_i),
   .tap_o  (tap_o),
   .load_o (load_o),
   .busy_o (busy_o),
   .done_o (done_o),
   .fail_o (fail_o)
);

// File: tb/test_eye_center_cal.sv
`timescale 1ns/1ps
module test_eye_center_cal;
   localparam int TAP_W  = 5;
   localparam int WORD_W = 8;
   localparam int SETTLE = 4;
   localparam int PASS   = 64;
   localparam int NTAPS  = 1 << TAP_W;

   // tap classes in the delay-line model
   localparam int C_GOOD   = 0;
   localparam int C_BAD    = 1;
   localparam int C_NOISY  = 2; // wrong only while settling
   localparam int C_LATE   = 3; // wrong only on last compared word
   localparam int C_EARLY  = 4; // wrong only on first compared word

   logic              clk = 1'b0;
   logic              rst_i;
   logic              start_i;
   logic [WORD_W-1:0] word_i, pattern_i;
   logic [TAP_W-1:0]  tap_o;
   logic              load_o, busy_o, done_o, fail_o;

   int check_cnt = 0;
   int fail_cnt  = 0;
   int cls [NTAPS];
   int cur_tap = 0;
   int word_k  = 0;
   int load_cnt = 0;
   int exp_tap  = 0;
   bit prev_load = 1'b0;

   always #2 clk = ~clk;

   eye_center_cal #(.TAP_W(TAP_W), .WORD_W(WORD_W), .SETTLE_CYCLES(SETTLE),
                    .PASS_WORDS(PASS)) i_eye_center_cal (
      .clk_i(clk), .rst_i(rst_i), .start_i(start_i), .word_i(word_i),
      .pattern_i(pattern_i), .tap_o(tap_o), .load_o(load_o), .busy_o(busy_o),
      .done_o(done_o), .fail_o(fail_o));

   task automatic check(input bit ok, input string req, input int act, input int exp);
      check_cnt++;
      if (!ok) begin
         fail_cnt++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic bit word_wrong(input int c, input int k);
      case (c)
         C_BAD:   return 1'b1;
         C_NOISY: return k < SETTLE;
         C_LATE:  return k == SETTLE + PASS - 1;
         C_EARLY: return k == SETTLE;
         default: return 1'b0;
      endcase
   endfunction

   function automatic bit tap_passes(input int c);
      return (c == C_GOOD) || (c == C_NOISY);
   endfunction

   // delay-line model, word source and load monitor
   always @(negedge clk) begin
      logic [WORD_W-1:0] pat;
      if (load_o) begin
         cur_tap = int'(tap_o);
         word_k  = 0;
         if (load_cnt < NTAPS)
            check(int'(tap_o) == load_cnt, "R3 sweep order", int'(tap_o), load_cnt);
         else begin
            check(busy_o == 1'b1, "R8 busy at final load", int'(busy_o), 1);
            check(int'(tap_o) == exp_tap, "R6/R7 final tap at load", int'(tap_o), exp_tap);
         end
         if (prev_load) check(1'b0, "R3 pulse width", 2, 1);
         load_cnt++;
      end else begin
         word_k++;
      end
      prev_load = load_o;
      pat = WORD_W'($urandom);
      pattern_i = pat;
      word_i = word_wrong(cls[cur_tap], word_k) ? (pat ^ WORD_W'(1 << ($urandom % WORD_W))) : pat;
   end

   task automatic run_case(input string name, input int extra_start);
      int lo = -1, hi = -1, t = 0;
      bit exp_fail;
      foreach (cls[i]) if (tap_passes(cls[i])) begin
         if (lo < 0) lo = i;
         hi = i;
      end
      exp_fail = (lo < 0);
      exp_tap  = exp_fail ? 0 : (lo + hi) / 2;
      load_cnt = 0;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      check(busy_o && load_o && tap_o == 0 && !done_o && !fail_o, {"R2 start ", name},
            {busy_o, load_o, done_o, fail_o}, 4'b1100);
      if (extra_start > 0) begin
         repeat (extra_start) @(negedge clk);
         start_i = 1'b1;                      // R9: ignored while busy
         @(negedge clk);
         start_i = 1'b0;
      end
      while (!done_o && t < 6000) begin
         @(negedge clk);
         t++;
      end
      check(done_o == 1'b1, {"R8 done ", name}, int'(done_o), 1);
      check(busy_o == 1'b0, {"R8 busy low ", name}, int'(busy_o), 0);
      check(int'(tap_o) == exp_tap, {"R6 final tap ", name}, int'(tap_o), exp_tap);
      check(fail_o == exp_fail, {"R7 fail flag ", name}, int'(fail_o), int'(exp_fail));
      check(load_cnt == NTAPS + 1, {"R3/R9 load count ", name}, load_cnt, NTAPS + 1);
      repeat (4) @(negedge clk);
      check(done_o && int'(tap_o) == exp_tap && !load_o, {"R10 hold after done ", name},
            int'(tap_o), exp_tap);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      check(1'b0, "watchdog", 0, 1);
      $display("%0d/%0d checks passed", check_cnt - fail_cnt, check_cnt);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      foreach (cls[i]) cls[i] = C_GOOD;
      rst_i = 1'b1;
      start_i = 1'b0;
      repeat (3) @(negedge clk);
      check(tap_o == 0 && !load_o && !busy_o && !done_o && !fail_o, "R1 reset state",
            {tap_o, load_o, busy_o, done_o, fail_o}, 0);
      rst_i = 1'b0;
      @(negedge clk);

      // all taps clean: (0+31)/2 = 15
      run_case("all good", 0);
      // nothing passes
      foreach (cls[i]) cls[i] = (i % 2) ? C_BAD : C_LATE;
      run_case("none good", 0);
      // only the top tap
      foreach (cls[i]) cls[i] = C_BAD;
      cls[NTAPS-1] = C_GOOD;
      run_case("top only", 0);
      // only tap 0, neighbours fail on a single word (R5)
      foreach (cls[i]) cls[i] = (i % 2) ? C_EARLY : C_LATE;
      cls[0] = C_NOISY;
      run_case("bottom only", 0);
      // window 10..20, settle noise inside (R4), single-word edges (R5); start while busy (R9)
      foreach (cls[i]) cls[i] = C_BAD;
      for (int i = 10; i <= 20; i++) cls[i] = (i % 3 == 0) ? C_NOISY : C_GOOD;
      cls[9] = C_LATE;
      cls[21] = C_EARLY;
      run_case("window 10..20", 500);
      // split window: taps 4 and 29 pass, holes between -> floor(33/2)=16
      foreach (cls[i]) cls[i] = C_BAD;
      cls[4] = C_GOOD;
      cls[29] = C_NOISY;
      run_case("split 4/29", 0);
      // random windows with random marginal taps
      for (int r = 0; r < 6; r++) begin
         int a = $urandom % NTAPS;
         int b = $urandom % NTAPS;
         int lo = (a < b) ? a : b;
         int hi = (a < b) ? b : a;
         foreach (cls[i]) begin
            if (i >= lo && i <= hi) cls[i] = ($urandom % 2) ? C_NOISY : C_GOOD;
            else cls[i] = 1 + 2 * ($urandom % 2) + (($urandom % 3 == 0) ? 1 : 0);
            if (cls[i] == C_NOISY && (i < lo || i > hi)) cls[i] = C_BAD;
         end
         run_case($sformatf("random %0d", r), (r == 2) ? 1000 : 0);
      end

      $display("%0d/%0d checks passed", check_cnt - fail_cnt, check_cnt);
      $finish;
   end
endmodule